// File: doc/BRIEF.md
# Command-Driven Entropy Generator with Automatic Reseeding

This block is a register-mapped random number source. Software writes a command word to start a generate or a reseed, polls a status word (or takes an interrupt) until the core is ready, and then reads the result from eight 32-bit result words. Entropy arrives on a single-bit input stream. While a generate runs, the core shifts one bit of that stream into the result storage on each clock. A reseed is modelled as a busy period of a fixed number of clocks. No conditioning or cryptographic post-processing is applied.

The core seeds itself once after reset. It counts output in 16-byte units and reseeds on its own once a programmed threshold is reached. Two sticky event flags record "data ready" and "seed done". Software clears each flag by writing a 1 to its bit. The interrupt line is derived from these flags through per-source enables and a global enable. A read-only identification word lets software check that it is talking to this core.

Top module: `trng_core`

## Requirements
- R1: Reset is synchronous and active high. After reset the core starts a reseed by itself: status reads with reseeding (bit 31) set and seeded (bit 9) clear. After SEED_CYCLES clocks the status reads 0x00000200 (only seeded set), and interrupt status bit 1 is set.
- R2: Offset 0xF0 reads the constant 0x000046bc.
- R3: Writing 0x01 to offset 0x00 while idle and seeded starts a generate, and status bit 30 reads 1 while it runs. The entropy bit sampled on the k-th rising edge after the write edge (k counted from 1) lands in result word (k-1)/32 at bit 31-((k-1)%32). Result word n is read at offset 0x20+4n.
- R4: Offset 0x08 bit 3 selects the output width. A value of 0 gives 128 bits: words 0..3 are filled in 128 clocks and words 4..7 keep their old contents. A value of 1 gives 256 bits: all eight words are filled in 256 clocks.
- R5: Writing 0x02 to offset 0x00 while idle starts a reseed lasting SEED_CYCLES clocks, with status reading 0x80000200. A generate command written during a reseed is held and starts when the reseed completes.
- R6: Offset 0x60 holds a 16-bit threshold in 16-byte units, and 0 disables the feature. A 128-bit generate counts 1 unit and a 256-bit generate counts 2. The count restarts at every reseed. When a completed generate brings the count to the threshold or beyond, the core enters a reseed on the next clock.
- R7: Interrupt status (offset 0x14) bit 0 is set when a generate completes and bit 1 when a reseed completes, whatever the enables are.
- R8: Writing 1 to an interrupt status bit clears it. Writing 0 leaves it unchanged.
- R9: Offset 0x10 holds the enables: bit 31 global, bit 1 seed done, bit 0 data ready. The irq output equals global AND (OR of enabled pending flags), registered one clock after the flags.
- R10: Command writes are ignored while a generate is running. A reseed command issued then neither reseeds nor disturbs the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid one clock later |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ent_bit | input | 1 | Entropy bit stream |
| irq | output | 1 | Interrupt request |

## Verification
Read data appears one clock after the read strobe, so the bench raises the strobe at a falling edge and samples on the next falling edge. A generate captures its first entropy bit on the edge after the command write and its last bit 128 or 256 edges after that write. Status and the ready flag change on that last edge, so they are visible to a read issued at the next falling edge. The bench changes the entropy input once per falling edge after the command, which ties each driven bit to the result position it must reach. The irq output lags the flags and enables by one register, so it is sampled two falling edges after the write that changes them.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_MODE  = 8'h08;
  localparam logic [7:0] OFS_IEN   = 8'h10;
  localparam logic [7:0] OFS_IST   = 8'h14;
  localparam logic [7:0] OFS_RES   = 8'h20;
  localparam logic [7:0] OFS_THR   = 8'h60;
  localparam logic [7:0] OFS_ID    = 8'hF0;

  localparam logic [7:0] OP_IDLE   = 8'h00;
  localparam logic [7:0] OP_GEN    = 8'h01;
  localparam logic [7:0] OP_SEED   = 8'h02;

  typedef enum logic [1:0] {PH_IDLE, PH_GEN, PH_SEED} phase_t;
endpackage

// File: rtl/trng_seq.sv
module trng_seq
  import trng_pkg::*;
#(
  parameter int SEED_CYCLES = 20,
  parameter int NWORDS      = 8,
  parameter int WORD_W      = 32,
  parameter int THR_W       = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      op_we,
  input  logic [7:0]                op_code,
  input  logic                      wide_sel,
  input  logic [THR_W-1:0]          thr,
  output logic                      seeded,
  output logic                      gen_busy,
  output logic                      seed_busy,
  output logic                      cap_en,
  output logic [$clog2(NWORDS)-1:0] cap_word,
  output logic [$clog2(WORD_W)-1:0] cap_bit,
  output logic                      gen_done,
  output logic                      seed_done
);
  localparam int NBITS  = NWORDS * WORD_W;
  localparam int CMAX   = (NBITS > SEED_CYCLES) ? NBITS : SEED_CYCLES;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int IDX_W  = $clog2(NWORDS);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(NBITS - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NBITS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_SEED   = CNT_W'(SEED_CYCLES - 1);

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic             wide_q;
  logic             pend;
  logic [THR_W:0]   units;
  logic [THR_W:0]   units_nx;
  logic             auto_go;

  assign gen_busy  = (ph == PH_GEN);
  assign seed_busy = (ph == PH_SEED);
  assign cap_en    = gen_busy;
  assign cap_word  = cnt[BIT_W +: IDX_W];
  assign cap_bit   = cnt[BIT_W-1:0];
  assign gen_done  = gen_busy && (cnt == (wide_q ? LAST_WIDE : LAST_NARROW));
  assign seed_done = seed_busy && (cnt == LAST_SEED);

  always_comb begin
    units_nx = units[THR_W] ? units
             : units + {{(THR_W-1){1'b0}}, wide_q, ~wide_q};
    auto_go  = (thr != '0) && (units_nx >= {1'b0, thr});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_SEED;
      cnt    <= '0;
      seeded <= 1'b0;
      pend   <= 1'b0;
      units  <= '0;
      wide_q <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (op_we && op_code == OP_GEN) begin
            ph     <= PH_GEN;
            cnt    <= '0;
            wide_q <= wide_sel;
          end else if (op_we && op_code == OP_SEED) begin
            ph    <= PH_SEED;
            cnt   <= '0;
            units <= '0;
          end
        end
        PH_SEED: begin
          if (op_we && op_code == OP_GEN) pend <= 1'b1;
          if (seed_done) begin
            seeded <= 1'b1;
            cnt    <= '0;
            if (pend || (op_we && op_code == OP_GEN)) begin
              ph     <= PH_GEN;
              wide_q <= wide_sel;
              pend   <= 1'b0;
            end else begin
              ph <= PH_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GEN: begin
          if (gen_done) begin
            cnt <= '0;
            if (auto_go) begin
              ph    <= PH_SEED;
              units <= '0;
            end else begin
              ph    <= PH_IDLE;
              units <= units_nx;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R5: output is only produced once the core holds a seed
  a_r5_gen_needs_seed: assert property (@(posedge clk) disable iff (rst)
    gen_busy |-> seeded);
  // R1: seeded never drops once reached
  a_r1_seeded_sticky: assert property (@(posedge clk) disable iff (rst)
    seeded |=> seeded);
  // R4: narrow output stays in the lower half of the words
  a_r4_narrow_half: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !wide_q) |-> (int'(cap_word) < NWORDS / 2));
  // R10: a running generate is never cut short by commands
  a_r10_gen_runs_on: assert property (@(posedge clk) disable iff (rst)
    (gen_busy && !gen_done) |=> gen_busy);
endmodule

// File: rtl/trng_collect.sv
module trng_collect #(
  parameter int NWORDS = 8,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      cap_en,
  input  logic [$clog2(NWORDS)-1:0] cap_word,
  input  logic [$clog2(WORD_W)-1:0] cap_bit,
  input  logic                      ent_bit,
  input  logic [$clog2(NWORDS)-1:0] rd_idx,
  output logic [WORD_W-1:0]         rd_word
);
  localparam logic [$clog2(WORD_W)-1:0] LAST_BIT = $clog2(WORD_W)'(WORD_W - 1);

  logic [WORD_W-1:0] store [NWORDS];
  logic [WORD_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (cap_en) begin
      shreg <= {shreg[WORD_W-3:0], ent_bit};
      if (cap_bit == LAST_BIT) store[cap_word] <= {shreg, ent_bit};
    end
    rd_word <= store[rd_idx];
  end
endmodule

// File: rtl/trng_irq.sv
module trng_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev_set,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_mask,
  input  logic [NSRC-1:0] src_en,
  input  logic            glb_en,
  output logic [NSRC-1:0] pending,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            pending[i] <= 1'b0;
      else if (ev_set[i]) pending[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) pending[i] <= 1'b0;
    end

    // R7: an event always leaves its flag set
    a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
      ev_set[i] |=> pending[i]);
    // R8: a one written without a new event clears the flag
    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[i] && !ev_set[i]) |=> !pending[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= glb_en && |(pending & src_en);
  end

  // R9: without the global enable the line stays low
  a_r9_global_gate: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq);
endmodule

// File: rtl/trng_core.sv
module trng_core
  import trng_pkg::*;
#(
  parameter int          SEED_CYCLES = 20,
  parameter int          NWORDS      = 8,
  parameter int          WORD_W      = 32,
  parameter int          THR_W       = 16,
  parameter logic [15:0] ID_CODE     = 16'h46bc
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ent_bit,
  output logic        irq
);
  localparam int IDX_W = $clog2(NWORDS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [8:0] RES_END = 9'(OFS_RES) + 9'(4 * NWORDS);

  logic             wide_q, glb_q;
  logic [1:0]       en_q;
  logic [THR_W-1:0] thr_q;
  logic             seeded, gen_busy, seed_busy, cap_en, gen_done, seed_done;
  logic [IDX_W-1:0] cap_word;
  logic [BIT_W-1:0] cap_bit;
  logic [1:0]       pending;
  logic [WORD_W-1:0] res_word;
  logic             res_hit, res_sel_q;
  logic [31:0]      reg_mux, reg_q;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[30:THR_W];
  assign res_hit = ({1'b0, bus_addr} >= 9'(OFS_RES)) && ({1'b0, bus_addr} < RES_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= 1'b0;
      glb_q  <= 1'b0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_MODE) wide_q <= bus_wdata[3];
      if (bus_addr == OFS_IEN) begin
        glb_q <= bus_wdata[31];
        en_q  <= bus_wdata[1:0];
      end
      if (bus_addr == OFS_THR) thr_q <= bus_wdata[THR_W-1:0];
    end
  end

  trng_seq #(
    .SEED_CYCLES(SEED_CYCLES), .NWORDS(NWORDS), .WORD_W(WORD_W), .THR_W(THR_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .op_we(bus_wr && bus_addr == OFS_CMD), .op_code(bus_wdata[7:0]),
    .wide_sel(wide_q), .thr(thr_q),
    .seeded(seeded), .gen_busy(gen_busy), .seed_busy(seed_busy),
    .cap_en(cap_en), .cap_word(cap_word), .cap_bit(cap_bit),
    .gen_done(gen_done), .seed_done(seed_done)
  );

  trng_collect #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_collect (
    .clk(clk), .cap_en(cap_en), .cap_word(cap_word), .cap_bit(cap_bit),
    .ent_bit(ent_bit), .rd_idx(bus_addr[2 +: IDX_W]), .rd_word(res_word)
  );

  trng_irq #(.NSRC(2)) u_irq (
    .clk(clk), .rst(rst),
    .ev_set({seed_done, gen_done}),
    .clr_we(bus_wr && bus_addr == OFS_IST), .clr_mask(bus_wdata[1:0]),
    .src_en(en_q), .glb_en(glb_q), .pending(pending), .irq(irq)
  );

  always_comb begin
    reg_mux = '0;
    case (bus_addr)
      OFS_STAT: reg_mux = {seed_busy, gen_busy, 20'd0, seeded, 9'd0};
      OFS_MODE: reg_mux = {28'd0, wide_q, 3'd0};
      OFS_IEN:  reg_mux = {glb_q, 29'd0, en_q};
      OFS_IST:  reg_mux = {30'd0, pending};
      OFS_THR:  reg_mux = 32'(thr_q);
      OFS_ID:   reg_mux = {16'd0, ID_CODE};
      default:  reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      res_sel_q <= 1'b0;
    end else if (bus_rd) begin
      reg_q     <= reg_mux;
      res_sel_q <= res_hit;
    end
  end

  assign bus_rdata = res_sel_q ? 32'(res_word) : reg_q;

  // R2: the identification word reads back unchanged
  a_r2_id_word: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_ID) |=> (bus_rdata == {16'd0, ID_CODE}));
endmodule

// File: tb/trng_core_test.sv
module trng_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEEDC = 20;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, ent_bit = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] model [8];
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  trng_core #(.SEED_CYCLES(SEEDC)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_bit(ent_bit), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic pat(input int p, input int k);
    case (p)
      0: return 1'b1;
      1: return k[0];
      2: return logic'((((k * 13) >> 2) ^ (k >> 5)) & 1);
      default: return (k % 3) == 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input int p, input int w);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[31-j] = pat(p, w * 32 + j);
    return r;
  endfunction

  // Runs one generate; bit k drives the (k+1)-th edge after the command edge
  task automatic gen_run(input int wide, input int p);
    int nb;
    nb = wide ? 256 : 128;
    wr(8'h08, wide ? 32'h8 : 32'h0);
    wr(8'h00, 32'h1);
    for (int k = 0; k < nb; k++) begin
      ent_bit = pat(p, k);
      @(negedge clk);
    end
    ent_bit = 1'b0;
    for (int w = 0; w < nb / 32; w++) model[w] = exp_word(p, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(8'h04, v); chk("R1 reseeding after reset", v, 32'h8000_0000);
    rd(8'h f0, v); chk("R2 id word", v, 32'h0000_46bc);
    n = 0;
    do begin rd(8'h04, v); n++; end while (v != 32'h200 && n < 100);
    chk("R1 seeded after self reseed", v, 32'h0000_0200);
    rd(8'h14, v); chk("R7 seed done flag", v, 32'h2);
    wr(8'h14, 32'h3);
    rd(8'h14, v); chk("R8 flags cleared", v, 32'h0);

    // R3 R4: sweep widths and entropy patterns
    for (int wide = 1; wide >= 0; wide--) begin
      for (int p = 0; p < 4; p++) begin
        gen_run(wide, p);
        for (int w = 0; w < 8; w++) begin
          rd(8'(8'h20 + 4 * w), v);
          chk(wide ? "R3 wide word" : "R4 narrow word / kept upper", v, model[w]);
        end
        rd(8'h14, v); chk("R7 ready flag", v & 32'h1, 32'h1);
        rd(8'h04, v); chk("R3 idle after generate", v, 32'h200);
        wr(8'h14, 32'h1);
      end
    end

    // R10: reseed command during generate is ignored
    ent_bit = 1'b1;
    wr(8'h08, 32'h8);
    wr(8'h00, 32'h1);
    rd(8'h04, v); chk("R3 generating flag", v, 32'h4000_0200);
    wr(8'h00, 32'h2);
    idle(300);
    rd(8'h04, v); chk("R10 no reseed after ignored cmd", v, 32'h200);
    rd(8'h14, v); chk("R10 only ready flag", v, 32'h1);
    rd(8'h20, v); chk("R10 word0 intact", v, 32'hFFFF_FFFF);
    rd(8'h3C, v); chk("R10 word7 intact", v, 32'hFFFF_FFFF);
    wr(8'h14, 32'h3);

    // R5: generate held during a reseed
    ent_bit = 1'b0;
    wr(8'h00, 32'h2);
    rd(8'h04, v); chk("R5 manual reseed", v, 32'h8000_0200);
    wr(8'h00, 32'h1);
    idle(320);
    rd(8'h20, v); chk("R5 deferred generate word0", v, 32'h0);
    rd(8'h3C, v); chk("R5 deferred generate word7", v, 32'h0);
    rd(8'h14, v); chk("R5 both flags", v, 32'h3);
    wr(8'h14, 32'h3);

    // R6: automatic reseed threshold
    wr(8'h00, 32'h2); idle(40);
    wr(8'h60, 32'h3);
    rd(8'h60, v); chk("R6 threshold readback", v, 32'h3);
    gen_run(0, 1); rd(8'h04, v); chk("R6 narrow unit 1", v, 32'h200);
    gen_run(0, 2); rd(8'h04, v); chk("R6 narrow unit 2", v, 32'h200);
    gen_run(0, 3); rd(8'h04, v); chk("R6 narrow unit 3 reseeds", v, 32'h8000_0200);
    idle(40);
    rd(8'h14, v); chk("R7 auto reseed done flag", v, 32'h3);
    wr(8'h14, 32'h3);
    gen_run(1, 1); rd(8'h04, v); chk("R6 wide units 2", v, 32'h200);
    gen_run(1, 2); rd(8'h04, v); chk("R6 wide units 4 reseeds", v, 32'h8000_0200);
    idle(40);
    wr(8'h60, 32'h0);
    for (int i = 0; i < 4; i++) begin
      gen_run(1, i); rd(8'h04, v); chk("R6 zero threshold disables", v, 32'h200);
    end
    wr(8'h14, 32'h3);

    // R9 R8: interrupt gating and write-one-to-clear
    gen_run(0, 1);
    wr(8'h10, 32'h1); idle(2);
    chk("R9 no irq without global", 32'(irq), 32'h0);
    wr(8'h10, 32'h8000_0001);
    rd(8'h10, v); chk("R9 enable readback", v, 32'h8000_0001);
    idle(1);
    chk("R9 irq on ready", 32'(irq), 32'h1);
    wr(8'h14, 32'h0); idle(1);
    rd(8'h14, v); chk("R8 zero write keeps flag", v, 32'h1);
    wr(8'h14, 32'h1); idle(2);
    chk("R9 irq drops after clear", 32'(irq), 32'h0);
    wr(8'h00, 32'h2); idle(40);
    wr(8'h10, 32'h8000_0002); idle(2);
    chk("R9 irq on seed done", 32'(irq), 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h14, v); chk("R8 clear bit0 only", v, 32'h2);
    wr(8'h14, 32'h2); idle(2);
    rd(8'h14, v); chk("R8 clear bit1", v, 32'h0);
    chk("R9 irq low after all cleared", 32'(irq), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule